// File: doc/BRIEF.md
# I2C Command and Measurement Readback Slave

This block is the serial side of a power-monitor style device. It listens on an I2C bus as a fast-mode slave and drives SDA in open-drain style: it only pulls the line low or lets it go. SCL and SDA are first synchronised to a fast system clock and filtered, and every protocol decision is then made on clean edges of the filtered lines. The slave address is a fixed 3-bit prefix followed by two already-decoded 2-bit strap values.

A write transfer carries one of two things. The first data byte either sets the 7-bit configuration word, or names one of the extended registers, whose new value then follows in the next byte. The block passes both kinds of write on as single-cycle strobes. A read transfer returns the latest measurement codes, packed according to which channels are enabled, or a single status byte. The data words are sampled once, when the address is acknowledged, so every byte of one read comes from the same conversion. While a conversion result is still pending, the block refuses read transfers by not acknowledging its own address.

The write outputs are valid-only streams. `cfg_wr_o` and `ext_wr_o` are each high for exactly one clock, with their data valid in that cycle. There is no ready signal, and the consumer must take the value in that cycle, because the bus cannot be held off. The read inputs are plain levels that the block samples when it needs them.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {3'b011, strap_hi_i, strap_lo_i}, sent MSB first with the R/W bit last (0 = write, 1 = read). Any other address leaves SDA released for the whole transfer.
- R2: A write transfer that holds only the address (START, address+W, ACK, STOP) is acknowledged and produces no write strobe.
- R3: In a write, a first data byte with bit 7 = 0 produces exactly one single-cycle `cfg_wr_o` pulse, with `cfg_data_o` equal to that byte's bits 6..0.
- R4: In a write, a first data byte with bit 7 = 1 selects extended register `byte[1:0]`. The second byte produces one single-cycle `ext_wr_o` pulse carrying that selector and the byte. Further bytes are acknowledged and produce no strobe.
- R5: With both channels enabled and status off, a read returns voltage[11:4], then current[11:4], then {voltage[3:0], current[3:0]}.
- R6: With exactly one channel enabled, or with neither (which counts as voltage), a read returns X[11:4] and then {X[3:0], 4'b0000}, where X is the enabled channel's code.
- R7: When `status_sel_i` is high, a read returns the status byte as its only byte, whatever the channel enables are.
- R8: The slave changes its SDA drive only while the filtered SCL is low, except that a START or STOP releases it. After the master NACKs a byte, SDA is released. Any byte requested beyond the read length reads as 0xFF.
- R9: When `conv_busy_i` is high at the end of an address byte with R/W = 1, the address is not acknowledged. Write transfers are acknowledged regardless of `conv_busy_i`.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on the protocol. The default is FILT_LEN = 8, which at 8 ns per clock rejects pulses of 50 ns.
- R11: The voltage, current and status values returned by one read are those present when its address was acknowledged. Later changes do not alter the bytes of that read.
- R12: A repeated START restarts the read byte sequence at the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| strap_hi_i | input | 2 | Decoded upper address strap, address bits 3..2 |
| strap_lo_i | input | 2 | Decoded lower address strap, address bits 1..0 |
| conv_busy_i | input | 1 | A single conversion is pending; reads are refused |
| volt_en_i | input | 1 | Voltage channel enabled |
| curr_en_i | input | 1 | Current channel enabled |
| status_sel_i | input | 1 | Read returns the status byte |
| volt_code_i | input | 12 | Latest voltage code |
| curr_code_i | input | 12 | Latest current code |
| status_i | input | 8 | Status byte |
| cfg_wr_o | output | 1 | Configuration write strobe (valid-only) |
| cfg_data_o | output | 7 | Configuration word for cfg_wr_o |
| ext_wr_o | output | 1 | Extended register write strobe (valid-only) |
| ext_sel_o | output | 2 | Extended register selector |
| ext_data_o | output | 8 | Extended register value |

## Verification
Several properties are checked on every clock. SDA drive may change only in the SCL-low phase or at a START/STOP. Both write strobes must last a single cycle. An address acknowledgement must follow a matching address, and a read acknowledgement must never follow a busy cycle. The filtered lines may move only after the synchronised input has held the new level. The byte packing for each channel mode, the 0xFF fill past the end, the snapshot taken at the address acknowledge, the restart after a repeated START and the rejection of short glitches depend on the content of whole transfers. Only the bench's directed and random transfers can show these.

// File: rtl/i2c_cmd_slave_pkg.sv
package i2c_cmd_slave_pkg;

  localparam int CODE_W  = 12;
  localparam int STRAP_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } slv_state_e;

  typedef enum logic [1:0] {
    RDM_VOLT,
    RDM_CURR,
    RDM_BOTH,
    RDM_STAT
  } rd_mode_e;

  function automatic rd_mode_e pick_mode(input logic ve, input logic ce, input logic ss);
    if (ss)            return RDM_STAT;
    else if (ve && ce) return RDM_BOTH;
    else if (ce)       return RDM_CURR;
    else               return RDM_VOLT;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 8,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      run_q  <= '0;
      lvl_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == lvl_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        lvl_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;

  // the clean level only follows a synchronised level that has already held
  assert_filter_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(sync_q[1]) == lvl_q && $past(sync_q[1], 2) == lvl_q));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_rd_packer.sv
module i2c_rd_packer
  import i2c_cmd_slave_pkg::*;
(
  input  rd_mode_e          mode_i,
  input  logic [CODE_W-1:0] volt_i,
  input  logic [CODE_W-1:0] curr_i,
  input  logic [7:0]        stat_i,
  input  logic [1:0]        idx_i,
  output logic [7:0]        byte_o
);

  localparam int HI_LSB = CODE_W - 8;

  logic [CODE_W-1:0] single;

  always_comb begin
    single = (mode_i == RDM_CURR) ? curr_i : volt_i;
    byte_o = 8'hFF;
    unique case (mode_i)
      RDM_STAT: if (idx_i == 2'd0) byte_o = stat_i;
      RDM_BOTH: begin
        unique case (idx_i)
          2'd0:    byte_o = volt_i[CODE_W-1:HI_LSB];
          2'd1:    byte_o = curr_i[CODE_W-1:HI_LSB];
          2'd2:    byte_o = {volt_i[HI_LSB-1:0], curr_i[HI_LSB-1:0]};
          default: byte_o = 8'hFF;
        endcase
      end
      default: begin
        unique case (idx_i)
          2'd0:    byte_o = single[CODE_W-1:HI_LSB];
          2'd1:    byte_o = {single[HI_LSB-1:0], 4'b0000};
          default: byte_o = 8'hFF;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_slave_pkg::*;
#(
  parameter int         FILT_LEN    = 8,
  parameter logic [2:0] ADDR_PREFIX = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [STRAP_W-1:0] strap_hi_i,
  input  logic [STRAP_W-1:0] strap_lo_i,
  input  logic              conv_busy_i,
  input  logic              volt_en_i,
  input  logic              curr_en_i,
  input  logic              status_sel_i,
  input  logic [CODE_W-1:0] volt_code_i,
  input  logic [CODE_W-1:0] curr_code_i,
  input  logic [7:0]        status_i,
  output logic              cfg_wr_o,
  output logic [6:0]        cfg_data_o,
  output logic              ext_wr_o,
  output logic [1:0]        ext_sel_o,
  output logic [7:0]        ext_data_o
);

  localparam int NLINE = 2;

  // ---------------- line conditioning ----------------
  logic [NLINE-1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .level_o(clean_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  // ---------------- protocol state ----------------
  slv_state_e        st_q;
  logic [3:0]        bcnt_q;
  logic [7:0]        sh_q;
  logic [7:0]        tx_q;
  logic              rw_q;
  logic              oe_q;
  logic [1:0]        wr_idx_q;
  logic              ext_mode_q;
  logic [1:0]        ext_sel_q;
  logic [1:0]        rd_idx_q;
  logic              mnack_q;
  logic [CODE_W-1:0] cap_v_q, cap_i_q;
  logic [7:0]        cap_s_q;
  rd_mode_e          mode_q;
  logic [6:0]        my_addr;
  logic [7:0]        pk_byte;

  assign my_addr = {ADDR_PREFIX, strap_hi_i, strap_lo_i};

  i2c_rd_packer u_pack (
    .mode_i(mode_q),
    .volt_i(cap_v_q),
    .curr_i(cap_i_q),
    .stat_i(cap_s_q),
    .idx_i (rd_idx_q),
    .byte_o(pk_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bcnt_q     <= '0;
      sh_q       <= '0;
      tx_q       <= 8'hFF;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      wr_idx_q   <= '0;
      ext_mode_q <= 1'b0;
      ext_sel_q  <= '0;
      rd_idx_q   <= '0;
      mnack_q    <= 1'b0;
      cap_v_q    <= '0;
      cap_i_q    <= '0;
      cap_s_q    <= '0;
      mode_q     <= RDM_VOLT;
      cfg_wr_o   <= 1'b0;
      cfg_data_o <= '0;
      ext_wr_o   <= 1'b0;
      ext_sel_o  <= '0;
      ext_data_o <= '0;
    end else begin
      cfg_wr_o <= 1'b0;
      ext_wr_o <= 1'b0;
      if (stop_ev) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_ev) begin
        st_q       <= ST_ADDR;
        bcnt_q     <= '0;
        oe_q       <= 1'b0;
        wr_idx_q   <= '0;
        rd_idx_q   <= '0;
        ext_mode_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise && bcnt_q != 4'd8) begin
              sh_q   <= {sh_q[6:0], sda_f};
              bcnt_q <= bcnt_q + 4'd1;
            end else if (scl_fall && bcnt_q == 4'd8) begin
              if (sh_q[7:1] == my_addr && !(sh_q[0] && conv_busy_i)) begin
                oe_q <= 1'b1;
                rw_q <= sh_q[0];
                st_q <= ST_AACK;
                if (sh_q[0]) begin
                  cap_v_q <= volt_code_i;
                  cap_i_q <= curr_code_i;
                  cap_s_q <= status_i;
                  mode_q  <= pick_mode(volt_en_i, curr_en_i, status_sel_i);
                end
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bcnt_q <= '0;
              if (rw_q) begin
                tx_q <= pk_byte;
                oe_q <= ~pk_byte[7];
                st_q <= ST_RBYTE;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: begin
            if (scl_rise && bcnt_q != 4'd8) begin
              sh_q   <= {sh_q[6:0], sda_f};
              bcnt_q <= bcnt_q + 4'd1;
            end else if (scl_fall && bcnt_q == 4'd8) begin
              oe_q <= 1'b1;
              st_q <= ST_WACK;
              unique case (wr_idx_q)
                2'd0: begin
                  if (!sh_q[7]) begin
                    cfg_wr_o   <= 1'b1;
                    cfg_data_o <= sh_q[6:0];
                  end else begin
                    ext_mode_q <= 1'b1;
                    ext_sel_q  <= sh_q[1:0];
                  end
                  wr_idx_q <= 2'd1;
                end
                2'd1: begin
                  if (ext_mode_q) begin
                    ext_wr_o   <= 1'b1;
                    ext_sel_o  <= ext_sel_q;
                    ext_data_o <= sh_q;
                  end
                  wr_idx_q <= 2'd2;
                end
                default: ;
              endcase
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q   <= 1'b0;
              bcnt_q <= '0;
              st_q   <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (bcnt_q == 4'd7) begin
                oe_q <= 1'b0;
                st_q <= ST_RACK;
                if (rd_idx_q != 2'd3) rd_idx_q <= rd_idx_q + 2'd1;
              end else begin
                tx_q   <= {tx_q[6:0], 1'b1};
                oe_q   <= ~tx_q[6];
                bcnt_q <= bcnt_q + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mnack_q <= sda_f;
            end else if (scl_fall) begin
              if (!mnack_q) begin
                tx_q   <= pk_byte;
                oe_q   <= ~pk_byte[7];
                bcnt_q <= '0;
                st_q   <= ST_RBYTE;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  // ---------------- assertions ----------------
  assert_drive_low_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_f) || $past(start_ev) || $past(stop_ev)));

  assert_ack_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK && $past(st_q) == ST_ADDR) |-> ($past(sh_q[7:1]) == $past(my_addr)));

  assert_busy_refuses_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK && $past(st_q) == ST_ADDR && rw_q) |-> !$past(conv_busy_i));

  assert_cfg_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |=> !cfg_wr_o);

  assert_ext_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_o |=> !ext_wr_o);

endmodule

// File: tb/i2c_cmd_slave_tb_top.sv
module i2c_cmd_slave_tb_top;

  localparam int Q = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o;
  wire  sda_bus = sda_m & ~sda_oe_o;
  logic [1:0] strap_hi = 2'd2, strap_lo = 2'd1;
  logic conv_busy = 1'b0, volt_en = 1'b1, curr_en = 1'b1, status_sel = 1'b0;
  logic [11:0] volt_code = 12'h000, curr_code = 12'h000;
  logic [7:0]  status_b = 8'h00;
  logic        cfg_wr_o, ext_wr_o;
  logic [6:0]  cfg_data_o;
  logic [1:0]  ext_sel_o;
  logic [7:0]  ext_data_o;

  i2c_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe_o),
    .strap_hi_i(strap_hi), .strap_lo_i(strap_lo), .conv_busy_i(conv_busy),
    .volt_en_i(volt_en), .curr_en_i(curr_en), .status_sel_i(status_sel),
    .volt_code_i(volt_code), .curr_code_i(curr_code), .status_i(status_b),
    .cfg_wr_o(cfg_wr_o), .cfg_data_o(cfg_data_o),
    .ext_wr_o(ext_wr_o), .ext_sel_o(ext_sel_o), .ext_data_o(ext_data_o)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 1'b0;
  int cfg_cnt = 0, ext_cnt = 0;
  logic [6:0] cfg_last;
  logic [1:0] ext_sel_last;
  logic [7:0] ext_last;
  bit glitch_en = 1'b0, mid_change = 1'b0;
  logic [7:0] rb [0:3];

  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_wr_o) begin cfg_cnt++; cfg_last = cfg_data_o; end
      if (ext_wr_o) begin ext_cnt++; ext_sel_last = ext_sel_o; ext_last = ext_data_o; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic t_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
  endtask

  task automatic t_bit_w(input logic b);
    sda_m = b;
    if (glitch_en) begin
      wq(8); scl_m = 1'b1; wq(5); scl_m = 1'b0; wq(Q - 13);
      scl_m = 1'b1; wq(10); sda_m = ~b; wq(5); sda_m = b; wq(2 * Q - 15);
    end else begin
      wq(Q); scl_m = 1'b1; wq(2 * Q);
    end
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic t_bit_r(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) t_bit_w(d[i]);
    t_bit_r(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) t_bit_r(d[i]);
    t_bit_w(!ack);
  endtask

  function automatic logic [6:0] my_addr();
    return {3'b011, strap_hi, strap_lo};
  endfunction

  function automatic int exp_len(input bit ve, input bit ce, input bit ss);
    if (ss) return 1;
    if (ve && ce) return 3;
    return 2;
  endfunction

  function automatic logic [7:0] exp_byte(input bit ve, input bit ce, input bit ss,
      input logic [11:0] v, input logic [11:0] c, input logic [7:0] s, input int k);
    logic [11:0] x;
    if (ss) return (k == 0) ? s : 8'hFF;
    if (ve && ce) begin
      case (k)
        0: return v[11:4];
        1: return c[11:4];
        2: return {v[3:0], c[3:0]};
        default: return 8'hFF;
      endcase
    end
    x = (ce && !ve) ? c : v;
    case (k)
      0: return x[11:4];
      1: return {x[3:0], 4'h0};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic do_read(input logic [6:0] a, input int n, output bit aok);
    bit ack;
    t_start();
    wbyte({a, 1'b1}, ack);
    aok = ack;
    if (ack) begin
      if (mid_change) begin
        volt_code = ~volt_code; curr_code = ~curr_code; status_b = ~status_b;
      end
      for (int k = 0; k < n; k++) rbyte(rb[k], k != n - 1);
    end
    t_stop();
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] b0,
      input logic [7:0] b1, input logic [7:0] b2, output bit allack);
    bit ack;
    logic [7:0] bytes [0:2];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    t_start();
    wbyte({a, 1'b0}, ack);
    allack = ack;
    if (ack) begin
      for (int k = 0; k < n; k++) begin
        wbyte(bytes[k], ack);
        allack = allack & ack;
      end
    end
    t_stop();
  endtask

  task automatic read_and_check(input string rq, input int n);
    bit aok;
    logic [11:0] v0, c0;
    logic [7:0] s0;
    bit ve, ce, ss;
    v0 = volt_code; c0 = curr_code; s0 = status_b;
    ve = volt_en; ce = curr_en; ss = status_sel;
    do_read(my_addr(), n, aok);
    chk(aok, {rq, " address ack"}, 32'(aok), 32'd1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = exp_byte(ve, ce, ss, v0, c0, s0, k);
      chk(rb[k] === e, rq, 32'(rb[k]), 32'(e));
    end
  endtask

  initial begin
    bit ok;
    int c0, e0;
    logic [7:0] b0, b1, first;
    void'($urandom(32'd20240611));
    wq(5);
    rst_n = 1'b1;
    wq(4);
    // reset state: released line, no strobes (R8, R3, R4)
    chk(sda_oe_o == 1'b0, "R8 reset release", 32'(sda_oe_o), 32'd0);
    chk(cfg_wr_o == 1'b0 && ext_wr_o == 1'b0, "R3 R4 reset strobes", 32'({cfg_wr_o, ext_wr_o}), 32'd0);

    // R2 quick command
    c0 = cfg_cnt; e0 = ext_cnt;
    do_write(my_addr(), 0, 8'h00, 8'h00, 8'h00, ok);
    chk(ok, "R2 quick ack", 32'(ok), 32'd1);
    chk(cfg_cnt == c0 && ext_cnt == e0, "R2 no strobe", 32'(cfg_cnt + ext_cnt), 32'(c0 + e0));

    // R1 foreign address not acknowledged
    do_write(my_addr() ^ 7'h04, 1, 8'h11, 8'h00, 8'h00, ok);
    chk(!ok, "R1 foreign address", 32'(ok), 32'd0);
    chk(cfg_cnt == c0, "R1 foreign no strobe", 32'(cfg_cnt), 32'(c0));

    // R3 command write
    do_write(my_addr(), 1, 8'h35, 8'h00, 8'h00, ok);
    chk(ok && cfg_cnt == c0 + 1, "R3 one strobe", 32'(cfg_cnt), 32'(c0 + 1));
    chk(cfg_last == 7'h35, "R3 data", 32'(cfg_last), 32'h35);

    // R4 extended write with trailing byte
    do_write(my_addr(), 3, 8'h82, 8'hA5, 8'h3C, ok);
    chk(ok, "R4 all acked", 32'(ok), 32'd1);
    chk(ext_cnt == e0 + 1, "R4 single strobe", 32'(ext_cnt), 32'(e0 + 1));
    chk(ext_sel_last == 2'd2 && ext_last == 8'hA5, "R4 sel and data",
        32'({ext_sel_last, ext_last}), 32'h2A5);
    chk(cfg_cnt == c0 + 1, "R4 no command strobe", 32'(cfg_cnt), 32'(c0 + 1));

    // R5 both channels
    volt_code = 12'hABC; curr_code = 12'h123; status_b = 8'h5A;
    volt_en = 1; curr_en = 1; status_sel = 0;
    read_and_check("R5 both", 3);
    // R6 voltage only, current only, neither
    volt_en = 1; curr_en = 0; read_and_check("R6 volt", 2);
    volt_en = 0; curr_en = 1; read_and_check("R6 curr", 2);
    volt_en = 0; curr_en = 0; read_and_check("R6 none", 2);
    // R7 status overrides
    volt_en = 1; curr_en = 1; status_sel = 1; read_and_check("R7 status", 1);
    status_sel = 0;

    // R8 bytes past the end and release after NACK
    volt_en = 1; curr_en = 0;
    read_and_check("R8 past end", 3);
    wq(2);
    chk(sda_oe_o == 1'b0, "R8 released after nack", 32'(sda_oe_o), 32'd0);

    // R9 busy refuses read, write still taken
    conv_busy = 1;
    do_read(my_addr(), 1, ok);
    chk(!ok, "R9 read refused", 32'(ok), 32'd0);
    c0 = cfg_cnt;
    do_write(my_addr(), 1, 8'h12, 8'h00, 8'h00, ok);
    chk(ok && cfg_cnt == c0 + 1, "R9 write accepted", 32'(cfg_cnt), 32'(c0 + 1));
    conv_busy = 0;

    // R10 glitches on both lines during a write
    c0 = cfg_cnt;
    glitch_en = 1;
    do_write(my_addr(), 1, 8'h2A, 8'h00, 8'h00, ok);
    glitch_en = 0;
    chk(ok, "R10 acked through glitches", 32'(ok), 32'd1);
    chk(cfg_cnt == c0 + 1 && cfg_last == 7'h2A, "R10 data intact", 32'(cfg_last), 32'h2A);

    // R11 snapshot at address acknowledge
    volt_en = 1; curr_en = 1;
    mid_change = 1;
    read_and_check("R11 snapshot", 3);
    mid_change = 0;

    // R12 repeated start restarts the sequence
    begin
      bit a1, a2;
      logic [7:0] e;
      volt_code = 12'h9F3; curr_code = 12'h46E;
      e = exp_byte(1, 1, 0, volt_code, curr_code, status_b, 0);
      t_start();
      wbyte({my_addr(), 1'b1}, a1);
      rbyte(rb[0], 1'b0);
      t_start();
      wbyte({my_addr(), 1'b1}, a2);
      rbyte(rb[1], 1'b0);
      t_stop();
      chk(a1 && a2, "R12 both acked", 32'({a1, a2}), 32'h3);
      chk(rb[1] === e, "R12 first byte again", 32'(rb[1]), 32'(e));
    end

    // random reads
    for (int r = 0; r < 8; r++) begin
      strap_hi = 2'($urandom); strap_lo = 2'($urandom);
      volt_code = 12'($urandom); curr_code = 12'($urandom); status_b = 8'($urandom);
      volt_en = 1'($urandom); curr_en = 1'($urandom); status_sel = ($urandom % 4) == 0;
      if (status_sel) read_and_check("R7 random", 1);
      else if (volt_en && curr_en) read_and_check("R5 random", 3);
      else read_and_check("R6 random", 2);
    end
    status_sel = 0;

    // random writes
    for (int r = 0; r < 6; r++) begin
      strap_hi = 2'($urandom); strap_lo = 2'($urandom);
      first = 8'($urandom); b1 = 8'($urandom);
      c0 = cfg_cnt; e0 = ext_cnt;
      if (!first[7]) begin
        do_write(my_addr(), 1, first, 8'h00, 8'h00, ok);
        chk(ok && cfg_cnt == c0 + 1 && cfg_last == first[6:0], "R3 random",
            32'(cfg_last), 32'(first[6:0]));
      end else begin
        b0 = {6'b100000, first[1:0]};
        do_write(my_addr(), 2, b0, b1, 8'h00, ok);
        chk(ok && ext_cnt == e0 + 1 && ext_sel_last == b0[1:0] && ext_last == b1, "R4 random",
            32'({ext_sel_last, ext_last}), 32'({b0[1:0], b1}));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule